// File: doc/BRIEF.md
# Hot/Cold DFA Fallback Stall Controller

This block sits beside a fast matcher that consumes a chunk of several input bytes per cycle but only knows a small hot subset of DFA states. When the fast path finds that a chunk would leave that hot subset, it raises an escape. The controller then freezes the fast pipeline and holds back the upstream byte source. It keeps the pending chunk and the state the chunk started from, and walks that chunk one byte per cycle through the complete transition table in an external memory. When the walk ends, it writes the final state back and releases the pipeline with a one-cycle continue pulse.

Fast operation is the normal mode. The slow walk is a detour taken only on an escape. Match reports from both paths leave on one output. Each report appears exactly once, either from the fast path while running or from the table walk while halted.

The table memory is addressed as `{state, byte}`, with the state in the upper bits. Each table word holds the next state in bits `[STATE_W-1:0]` and an accept flag in bit `STATE_W`. The memory answers one cycle after each request.

Top module: `dfa_fallback_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `halt_o` is 0, `in_ready_o` is 1, `mem_req_o` is 0, `wb_valid_o` is 0, `resume_o` is 0 and `match_o` is 0.
- R2: While running, an `esc_valid_i` cycle drops `in_ready_o` in that same cycle. `halt_o` is 1 from the next cycle and stays 1 until the continue pulse has been given. `in_ready_o` stays 0 for the whole time `halt_o` is 1.
- R3: The first table read is issued in the cycle after the escape, at `{saved start state, byte 0}`. Byte 0 is chunk bits `[BYTE_W-1:0]` and byte i is bits `[i*BYTE_W +: BYTE_W]`. Each later read is issued one cycle after the previous one, at `{next state of the previous table word, byte i}`.
- R4: Exactly `CHUNK_BYTES` reads are issued for every escape, whatever intermediate states are visited.
- R5: One cycle after the last read, `wb_valid_o` pulses for one cycle and `wb_state_o` carries the next-state field of the last returned word.
- R6: `resume_o` pulses in the cycle after `wb_valid_o`. In the cycle after that, `halt_o` is 0 and `in_ready_o` is 1 again, so an escape costs `CHUNK_BYTES`+3 cycles.
- R7: While running, `match_o` follows `fast_match_i`. During the walk, `match_o` is 1 in each cycle where a returned table word has its accept bit (bit `STATE_W`) set.
- R8: While `halt_o` is 1, `fast_match_i` and `esc_valid_i` have no effect. The walk, the written-back state and `match_o` are unchanged by them.
- R9: `mem_req_o` is only ever asserted while `halt_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esc_valid_i | input | 1 | Escape request from the fast path's validate stage |
| esc_chunk_i | input | CHUNK_BYTES*BYTE_W | Pending chunk, byte 0 in the low bits |
| esc_state_i | input | STATE_W | State the pending chunk starts from |
| fast_match_i | input | 1 | Match report from the fast path |
| halt_o | output | 1 | Hold context in all fast pipeline stages |
| in_ready_o | output | 1 | Upstream may deliver a new chunk |
| mem_req_o | output | 1 | Full-table read request |
| mem_addr_o | output | STATE_W+BYTE_W | Read address `{state, byte}` |
| mem_rdata_i | input | STATE_W+1 | Table word returned one cycle after the request |
| wb_valid_o | output | 1 | Final state write-back strobe |
| wb_state_o | output | STATE_W | Final state of the walked chunk |
| resume_o | output | 1 | Continue pulse to the pipeline |
| match_o | output | 1 | Merged match report |

## Verification
The assertions assume that `mem_rdata_i` is exactly the word for the address requested one cycle earlier. The bench guarantees this with a registered model of the table, computed from an arithmetic next-state function. The assertions also assume that the pipeline obeys `halt_o`. The sweep nonetheless drives `fast_match_i` and `esc_valid_i` high throughout a walk, to show that they are ignored, and lowers them before the block returns to running. Every start state is combined with several chunk patterns, and the bench follows the same walk in its own model to predict each address, accept pulse and final state.

// File: rtl/dfa_fb_pkg.sv
`timescale 1ns/1ps
package dfa_fb_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_WALK   = 2'd2,
    ST_RESUME = 2'd3
  } fb_state_e;
endpackage

// File: rtl/dfa_fb_seq.sv
`timescale 1ns/1ps
module dfa_fb_seq
  import dfa_fb_pkg::*;
#(
  parameter int CHUNK_BYTES = 4,
  localparam int IDX_W = $clog2(CHUNK_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             esc_valid_i,
  output fb_state_e        state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             capture_o,
  output logic             last_o
);
  fb_state_e        state_q;
  logic [IDX_W-1:0] idx_q;

  assign capture_o = (state_q == ST_RUN) && esc_valid_i;
  assign last_o    = (idx_q == IDX_W'(CHUNK_BYTES));
  assign state_o   = state_q;
  assign idx_o     = idx_q;

  // idx_q: next chunk byte to issue; HALT issues byte 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          idx_q <= '0;
          if (esc_valid_i) state_q <= ST_HALT;
        end
        ST_HALT: begin
          idx_q   <= IDX_W'(1);
          state_q <= ST_WALK;
        end
        ST_WALK: begin
          if (last_o) state_q <= ST_RESUME;
          else        idx_q   <= idx_q + IDX_W'(1);
        end
        default: begin
          idx_q   <= '0;
          state_q <= ST_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/dfa_fb_chunk_buf.sv
`timescale 1ns/1ps
module dfa_fb_chunk_buf #(
  parameter int CHUNK_BYTES = 4,
  parameter int BYTE_W      = 8,
  parameter int STATE_W     = 4,
  localparam int IDX_W      = $clog2(CHUNK_BYTES + 1),
  localparam int CHUNK_W    = CHUNK_BYTES * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic [STATE_W-1:0] start_state_o
);
  logic [CHUNK_W-1:0] chunk_q;
  logic [STATE_W-1:0] state_q;
  logic [BYTE_W-1:0]  bytes [CHUNK_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chunk_q <= '0;
      state_q <= '0;
    end else if (capture_i) begin
      chunk_q <= chunk_i;
      state_q <= state_i;
    end
  end

  for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_split
    assign bytes[g] = chunk_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < CHUNK_BYTES; i++)
      if (idx_i == IDX_W'(i)) byte_o = bytes[i];
  end

  assign start_state_o = state_q;
endmodule

// File: rtl/dfa_fb_walker.sv
`timescale 1ns/1ps
module dfa_fb_walker
  import dfa_fb_pkg::*;
#(
  parameter int STATE_W = 4,
  parameter int BYTE_W  = 8,
  localparam int ADDR_W = STATE_W + BYTE_W,
  localparam int WORD_W = STATE_W + 1
) (
  input  fb_state_e          state_i,
  input  logic               last_i,
  input  logic [STATE_W-1:0] start_state_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               wb_valid_o,
  output logic [STATE_W-1:0] wb_state_o,
  output logic               hit_o
);
  logic               walking;
  logic [STATE_W-1:0] cur_state;

  assign walking = (state_i == ST_WALK);
  // returned word feeds the next address directly: one byte per cycle
  assign cur_state  = walking ? mem_rdata_i[STATE_W-1:0] : start_state_i;
  assign mem_req_o  = (state_i == ST_HALT) || (walking && !last_i);
  assign mem_addr_o = {cur_state, byte_i};
  assign wb_valid_o = walking && last_i;
  assign wb_state_o = cur_state;
  assign hit_o      = walking && mem_rdata_i[STATE_W];
endmodule

// File: rtl/dfa_fallback_ctrl.sv
`timescale 1ns/1ps
module dfa_fallback_ctrl
  import dfa_fb_pkg::*;
#(
  parameter int CHUNK_BYTES = 4,
  parameter int STATE_W     = 4,
  parameter int BYTE_W      = 8,
  localparam int ADDR_W     = STATE_W + BYTE_W,
  localparam int WORD_W     = STATE_W + 1,
  localparam int CHUNK_W    = CHUNK_BYTES * BYTE_W,
  localparam int IDX_W      = $clog2(CHUNK_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               esc_valid_i,
  input  logic [CHUNK_W-1:0] esc_chunk_i,
  input  logic [STATE_W-1:0] esc_state_i,
  input  logic               fast_match_i,
  output logic               halt_o,
  output logic               in_ready_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               wb_valid_o,
  output logic [STATE_W-1:0] wb_state_o,
  output logic               resume_o,
  output logic               match_o
);
  fb_state_e          state;
  logic [IDX_W-1:0]   idx;
  logic               capture;
  logic               last;
  logic [BYTE_W-1:0]  cur_byte;
  logic [STATE_W-1:0] start_state;
  logic               walk_hit;

  dfa_fb_seq #(.CHUNK_BYTES(CHUNK_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .esc_valid_i(esc_valid_i),
    .state_o    (state),
    .idx_o      (idx),
    .capture_o  (capture),
    .last_o     (last)
  );

  dfa_fb_chunk_buf #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .BYTE_W     (BYTE_W),
    .STATE_W    (STATE_W)
  ) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .capture_i    (capture),
    .chunk_i      (esc_chunk_i),
    .state_i      (esc_state_i),
    .idx_i        (idx),
    .byte_o       (cur_byte),
    .start_state_o(start_state)
  );

  dfa_fb_walker #(.STATE_W(STATE_W), .BYTE_W(BYTE_W)) u_walk (
    .state_i      (state),
    .last_i       (last),
    .start_state_i(start_state),
    .byte_i       (cur_byte),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .wb_valid_o   (wb_valid_o),
    .wb_state_o   (wb_state_o),
    .hit_o        (walk_hit)
  );

  assign halt_o     = (state != ST_RUN);
  assign in_ready_o = (state == ST_RUN) && !esc_valid_i;
  assign resume_o   = (state == ST_RESUME);
  // fast reports only count while running; walk reports only while halted
  assign match_o    = ((state == ST_RUN) && fast_match_i) || walk_hit;
endmodule

// File: rtl/dfa_fallback_ctrl_chk.sv
`timescale 1ns/1ps
module dfa_fallback_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic esc_valid_i,
  input logic halt_o,
  input logic in_ready_o,
  input logic mem_req_o,
  input logic wb_valid_o,
  input logic resume_o
);
  a_r2_halt_on_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && esc_valid_i) |=> halt_o);

  a_r2_ready_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !in_ready_o);

  a_r9_req_only_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> halt_o);

  a_r5_wb_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> ($past(mem_req_o) && !mem_req_o));

  a_r6_resume_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> resume_o);

  a_r6_release_after_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !halt_o);

  a_r6_resume_while_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> halt_o);

  a_r4_phases_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, wb_valid_o, resume_o}));
endmodule

bind dfa_fallback_ctrl dfa_fallback_ctrl_chk u_chk (.*);

// File: tb/dfa_fallback_ctrl_tb.sv
`timescale 1ns/1ps
module dfa_fallback_ctrl_tb;
  localparam int K  = 4;
  localparam int SW = 4;
  localparam int BW = 8;
  localparam int AW = SW + BW;
  localparam int WW = SW + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic esc_valid_i = 1'b0;
  logic [K*BW-1:0] esc_chunk_i = '0;
  logic [SW-1:0] esc_state_i = '0;
  logic fast_match_i = 1'b0;
  logic halt_o, in_ready_o, mem_req_o, wb_valid_o, resume_o, match_o;
  logic [AW-1:0] mem_addr_o;
  logic [WW-1:0] mem_rdata = '0;
  logic [SW-1:0] wb_state_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dfa_fallback_ctrl #(.CHUNK_BYTES(K), .STATE_W(SW), .BYTE_W(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .esc_valid_i(esc_valid_i),
    .esc_chunk_i(esc_chunk_i), .esc_state_i(esc_state_i),
    .fast_match_i(fast_match_i), .halt_o(halt_o), .in_ready_o(in_ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
    .wb_valid_o(wb_valid_o), .wb_state_o(wb_state_o), .resume_o(resume_o),
    .match_o(match_o)
  );

  // table model: next = (5*s + b + b/16) mod 16, accept when next == 15
  function automatic logic [WW-1:0] tbl(input logic [SW-1:0] s, input logic [BW-1:0] b);
    int n;
    n = (5 * int'(s) + int'(b) + int'(b) / 16) % 16;
    return {(n == 15), SW'(n)};
  endfunction

  always_ff @(posedge clk)
    if (mem_req_o) mem_rdata <= tbl(mem_addr_o[AW-1:BW], mem_addr_o[BW-1:0]);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_escape(input int s, input logic [K*BW-1:0] chunk, input bit noise);
    logic [SW-1:0] cur;
    logic [WW-1:0] w;
    bit acc;
    @(negedge clk);
    fast_match_i = 1'b1;
    #1 chk("R7 run passthrough high", int'(match_o), 1);
    fast_match_i = 1'b0;
    #0.1 chk("R7 run passthrough low", int'(match_o), 0);
    esc_valid_i = 1'b1;
    esc_chunk_i = chunk;
    esc_state_i = SW'(s);
    #0.1 chk("R2 ready drops with escape", int'(in_ready_o), 0);
    chk("R2 no halt yet", int'(halt_o), 0);
    cur = SW'(s);
    acc = 1'b0;
    for (int e = 0; e <= K + 2; e++) begin
      @(negedge clk);
      esc_valid_i  = noise && (e <= K);
      fast_match_i = noise && (e <= K);
      esc_state_i  = ~SW'(s);
      esc_chunk_i  = ~chunk;
      #1;
      if (e < K) begin
        chk("R2 halted", int'(halt_o), 1);
        chk("R2 ready low", int'(in_ready_o), 0);
        chk("R4 read issued", int'(mem_req_o), 1);
        chk("R3 address", int'(mem_addr_o), int'({cur, chunk[e*BW +: BW]}));
        chk("R8 R7 walk match", int'(match_o), (e == 0) ? 0 : int'(acc));
        w   = tbl(cur, chunk[e*BW +: BW]);
        acc = w[SW];
        cur = w[SW-1:0];
      end else if (e == K) begin
        chk("R4 no extra read", int'(mem_req_o), 0);
        chk("R5 wb strobe", int'(wb_valid_o), 1);
        chk("R5 R8 wb state", int'(wb_state_o), int'(cur));
        chk("R7 last walk match", int'(match_o), int'(acc));
        chk("R6 no early resume", int'(resume_o), 0);
      end else if (e == K + 1) begin
        chk("R6 resume pulse", int'(resume_o), 1);
        chk("R6 still halted", int'(halt_o), 1);
        chk("R5 wb single", int'(wb_valid_o), 0);
        chk("R8 match quiet", int'(match_o), 0);
      end else begin
        chk("R6 released", int'(halt_o), 0);
        chk("R6 ready back", int'(in_ready_o), 1);
        chk("R6 resume single", int'(resume_o), 0);
        chk("R9 no read running", int'(mem_req_o), 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 halt", int'(halt_o), 0);
    chk("R1 ready", int'(in_ready_o), 1);
    chk("R1 req", int'(mem_req_o), 0);
    chk("R1 wb", int'(wb_valid_o), 0);
    chk("R1 resume", int'(resume_o), 0);
    chk("R1 match", int'(match_o), 0);
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 6; p++) begin
        logic [K*BW-1:0] ch;
        for (int i = 0; i < K; i++)
          ch[i*BW +: BW] = BW'((s * 37 + p * 71 + i * 13 + p * i * 29) & 255);
        do_escape(s, ch, p[0]);
      end
    end
    do_escape(0, {8'h0F, 8'h0F, 8'h0F, 8'h0F}, 1'b1);
    do_escape(15, '1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule